// File: doc/BRIEF.md
# Command Launch Register Slave

This block is a 16-bit register slave on a simple host bus. The host uses it to start long-running routines, such as self-test and calibration, that a separate execution engine carries out. The host first loads a parameter and then writes a command code. The block checks the request and hands it to the engine as a one-cycle request pulse, together with a code and a parameter that stay stable. It then reports the engine as busy until the engine returns a done pulse.

Bit 15 of the command register does two jobs. On a write, a set bit 15 marks the word as a command. On a read, bit 15 is the busy flag. The host must see that flag clear before it loads a new parameter and issues a new code. A single-channel test request whose channel number is out of range is refused. The block records the refusal in an error bit and does not bother the engine.

The block also serves constant identification words, one read-only constant test word, a free scratch word and three parameter words. Of these, only the first parameter word is consumed by any command.

Top module: `cmd_hshk_regs`

## Requirements
- R1: After reset, bus reads show the command register, all three parameter words and the scratch word as 0x0000, and cmd_valid is low.
- R2: Word address 0x00 reads 0xFEEE, address 0x01 reads 0x57DA and address 0x21 reads 0xABCD; writes to these addresses change nothing.
- R3: Parameter words at addresses 0x11, 0x12 and 0x13, and the scratch word at 0x20, return the last full 16-bit value written. Only whole words are written. Any unmapped address reads 0x0000.
- R4: The command register sits at address 0x10. While idle, a write there with bit 15 set and an acceptable code raises cmd_valid in the next cycle. It sets cmd_code to the written word and cmd_param to the first parameter word as it stood at the write. The register then reads {busy=1 in bit 15, error in bit 14, code bits 13:0 in bits 13:0}.
- R5: cmd_valid is high for exactly one cycle per accepted command. cmd_code and cmd_param hold their values until the next accepted command.
- R6: When eng_done is sampled high while busy, bit 15 reads 0 from the next cycle on. eng_done while idle has no effect.
- R7: A command-register write while busy is ignored: no pulse, and cmd_code is unchanged. This also holds when the write falls in the same cycle as eng_done.
- R8: Code 0x8408 (single-channel test) is accepted only when the first parameter word is 15 or less. Otherwise no pulse is raised, busy stays 0 and bit 14 (error) reads 1. Error clears on the next accepted command.
- R9: A command-register write with bit 15 clear is ignored: no pulse, busy stays 0 and the readback is unchanged.
- R10: Codes 0x8401 (full self-test) and 0x8409 (supply check), and any other code with bit 15 set other than 0x8408, are issued whatever the parameter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| cmd_valid | output | 1 | One-cycle command request to the engine |
| cmd_code | output | 16 | Code of the last accepted command |
| cmd_param | output | 16 | Parameter captured with that command |
| eng_done | input | 1 | Completion pulse from the engine |

## Verification
Completion and a new launch can meet in one cycle. The engine's done pulse can arrive on the same edge as a host write to the command register. The bench drives eng_done and a command write together on purpose. It then expects busy to read clear, no request pulse, and cmd_code still holding the earlier command, because the write was judged against the busy flag as it stood before that edge. Constrained random traffic adds sequences where a second write lands while busy, and out-of-range channel numbers against in-range ones.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int DW = 16;

  localparam logic [7:0] ADR_MFR   = 8'h00;
  localparam logic [7:0] ADR_TYPE  = 8'h01;
  localparam logic [7:0] ADR_CMD   = 8'h10;
  localparam logic [7:0] ADR_PRM0  = 8'h11;
  localparam logic [7:0] ADR_SCR   = 8'h20;
  localparam logic [7:0] ADR_FIXT  = 8'h21;

  localparam logic [DW-1:0] VAL_MFR  = 16'hFEEE;
  localparam logic [DW-1:0] VAL_TYPE = 16'h57DA;
  localparam logic [DW-1:0] VAL_FIXT = 16'hABCD;

  localparam logic [DW-1:0] CODE_FULL = 16'h8401;
  localparam logic [DW-1:0] CODE_CHAN = 16'h8408;
  localparam logic [DW-1:0] CODE_PWR  = 16'h8409;
endpackage

// File: rtl/cmd_check.sv
module cmd_check
  import cmdreg_pkg::*;
#(
  parameter int CHAN_MAX = 15
) (
  input  logic [DW-1:0] code_in,
  input  logic [DW-1:0] param_in,
  output logic          launch,
  output logic          refuse
);
  logic is_cmd;
  logic chan_bad;

  always_comb begin
    is_cmd   = code_in[DW-1];
    chan_bad = (code_in == CODE_CHAN) && (param_in > DW'(CHAN_MAX));
    launch   = is_cmd && !chan_bad;
    refuse   = is_cmd && chan_bad;
  end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import cmdreg_pkg::*;
#(
  parameter int CHAN_MAX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          launch,
  input  logic          refuse,
  input  logic [DW-1:0] code_in,
  input  logic [DW-1:0] param_in,
  input  logic          eng_done,
  output logic          busy,
  output logic          err,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_code,
  output logic [DW-1:0] cmd_param
);
  logic          busy_q, busy_d;
  logic          err_q, err_d;
  logic          vld_q, vld_d;
  logic [DW-1:0] code_q, code_d;
  logic [DW-1:0] prm_q, prm_d;
  logic          accept, load;

  always_comb begin
    accept = cmd_we && !busy_q;
    load   = accept && launch;
    busy_d = busy_q;
    if (busy_q && eng_done) busy_d = 1'b0;
    if (load)               busy_d = 1'b1;
    err_d = err_q;
    if (load)                  err_d = 1'b0;
    else if (accept && refuse) err_d = 1'b1;
    vld_d  = load;
    code_d = load ? code_in  : code_q;
    prm_d  = load ? param_in : prm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
      code_q <= '0;
      prm_q  <= '0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      vld_q  <= vld_d;
      code_q <= code_d;
      prm_q  <= prm_d;
    end
  end

  assign busy      = busy_q;
  assign err       = err_q;
  assign cmd_valid = vld_q;
  assign cmd_code  = code_q;
  assign cmd_param = prm_q;

  assert_valid_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> !busy);
  assert_busy_holds_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cmd_code) && $stable(cmd_param) && !cmd_valid));
  assert_chan_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CODE_CHAN) |-> (cmd_param <= DW'(CHAN_MAX)));
  assert_refuse_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && refuse) |=> (!cmd_valid && err && !busy));
endmodule

// File: rtl/cmd_hshk_regs.sv
module cmd_hshk_regs
  import cmdreg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int N_PARAM  = 3,
  parameter int CHAN_MAX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  output logic [DW-1:0]     bus_rdata,
  output logic              cmd_valid,
  output logic [DW-1:0]     cmd_code,
  output logic [DW-1:0]     cmd_param,
  input  logic              eng_done
);
  localparam int CODE_LO = DW - 2;

  logic [DW-1:0] prm_q [N_PARAM];
  logic [DW-1:0] scr_q, scr_d;
  logic          scr_we, cmd_we;
  logic          launch, refuse, busy, err;

  assign cmd_we = bus_wr && (bus_addr == ADDR_W'(ADR_CMD));
  assign scr_we = bus_wr && (bus_addr == ADDR_W'(ADR_SCR));

  for (genvar g = 0; g < N_PARAM; g++) begin : g_prm
    logic          we;
    logic [DW-1:0] nxt;
    always_comb begin
      we  = bus_wr && (bus_addr == ADDR_W'(ADR_PRM0) + ADDR_W'(g));
      nxt = we ? bus_wdata : prm_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prm_q[g] <= '0;
      else        prm_q[g] <= nxt;
    end
  end

  always_comb scr_d = scr_we ? bus_wdata : scr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scr_q <= '0;
    else        scr_q <= scr_d;
  end

  cmd_check #(.CHAN_MAX(CHAN_MAX)) i_check (
    .code_in (bus_wdata),
    .param_in(prm_q[0]),
    .launch  (launch),
    .refuse  (refuse)
  );

  cmd_seq #(.CHAN_MAX(CHAN_MAX)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .launch   (launch),
    .refuse   (refuse),
    .code_in  (bus_wdata),
    .param_in (prm_q[0]),
    .eng_done (eng_done),
    .busy     (busy),
    .err      (err),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .cmd_param(cmd_param)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_MFR))       bus_rdata = VAL_MFR;
    else if (bus_addr == ADDR_W'(ADR_TYPE)) bus_rdata = VAL_TYPE;
    else if (bus_addr == ADDR_W'(ADR_FIXT)) bus_rdata = VAL_FIXT;
    else if (bus_addr == ADDR_W'(ADR_SCR))  bus_rdata = scr_q;
    else if (bus_addr == ADDR_W'(ADR_CMD))  bus_rdata = {busy, err, cmd_code[CODE_LO-1:0]};
    else begin
      for (int k = 0; k < N_PARAM; k++)
        if (bus_addr == ADDR_W'(ADR_PRM0) + ADDR_W'(k)) bus_rdata = prm_q[k];
    end
  end

  assert_issue_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_code[DW-1]);
  assert_issue_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(busy));
  assert_fixed_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(ADR_FIXT)) |-> (bus_rdata == VAL_FIXT));
endmodule

// File: tb/test_cmd_hshk_regs.sv
module test_cmd_hshk_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_rdata;
  logic        cmd_valid;
  logic [15:0] cmd_code, cmd_param;
  logic        eng_done = 1'b0;

  int errors = 0;
  int checks = 0;
  logic        exp_busy, exp_err;
  logic [15:0] exp_code, exp_param;

  always #4 clk = ~clk;

  cmd_hshk_regs i_cmd_hshk_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_param(cmd_param), .eng_done(eng_done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  function automatic logic [15:0] cmd_read();
    return {exp_busy, exp_err, exp_code[13:0]};
  endfunction

  // Model of a command write; returns the expected cmd_valid
  function automatic logic model_cmd(input logic [15:0] c, input logic [15:0] p);
    if (exp_busy || !c[15]) return 1'b0;
    if (c == 16'h8408 && p > 16'd15) begin
      exp_err = 1'b1;
      return 1'b0;
    end
    exp_busy = 1'b1; exp_err = 1'b0; exp_code = c; exp_param = p;
    return 1'b1;
  endfunction

  task automatic issue(input string req, input logic [15:0] c, input logic [15:0] p);
    logic v;
    logic [15:0] d;
    wr(8'h11, p);
    v = model_cmd(c, p);
    wr(8'h10, c);
    chk({req, " valid"}, {15'b0, cmd_valid}, {15'b0, v});
    chk({req, " code"}, cmd_code, exp_code);
    chk({req, " param"}, cmd_param, exp_param);
    rd(8'h10, d);
    chk({req, " readback"}, d, cmd_read());
    @(negedge clk);
    chk("R5 pulse ends", {15'b0, cmd_valid}, 16'h0);
  endtask

  task automatic finish_cmd();
    done_pulse();
    exp_busy = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd7741));
    exp_busy = 0; exp_err = 0; exp_code = 0; exp_param = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h10, d); chk("R1 cmd", d, 16'h0000);
    rd(8'h11, d); chk("R1 prm0", d, 16'h0000);
    rd(8'h12, d); chk("R1 prm1", d, 16'h0000);
    rd(8'h13, d); chk("R1 prm2", d, 16'h0000);
    rd(8'h20, d); chk("R1 scratch", d, 16'h0000);
    chk("R1 valid", {15'b0, cmd_valid}, 16'h0);

    // R2 identification and fixed words
    rd(8'h00, d); chk("R2 mfr", d, 16'hFEEE);
    rd(8'h01, d); chk("R2 type", d, 16'h57DA);
    rd(8'h21, d); chk("R2 fixed", d, 16'hABCD);
    wr(8'h21, 16'h1234); rd(8'h21, d); chk("R2 fixed after write", d, 16'hABCD);
    wr(8'h00, 16'h0000); rd(8'h00, d); chk("R2 mfr after write", d, 16'hFEEE);

    // R3 scratch, params and unmapped
    wr(8'h20, 16'h5AA5); rd(8'h20, d); chk("R3 scratch", d, 16'h5AA5);
    wr(8'h20, 16'hFFFF); rd(8'h20, d); chk("R3 scratch ones", d, 16'hFFFF);
    wr(8'h12, 16'hC0DE); rd(8'h12, d); chk("R3 prm1", d, 16'hC0DE);
    wr(8'h13, 16'h0F0F); rd(8'h13, d); chk("R3 prm2", d, 16'h0F0F);
    rd(8'h7F, d); chk("R3 unmapped", d, 16'h0000);

    // R6 done while idle has no effect
    done_pulse(); rd(8'h10, d); chk("R6 idle done", d, cmd_read());

    // R10 / R4 full self-test, param ignored
    issue("R4 R10 full", 16'h8401, 16'h0063);
    finish_cmd(); rd(8'h10, d); chk("R6 busy clears", d, cmd_read());

    // R8 boundary: 15 accepted, 16 refused
    issue("R8 chan15", 16'h8408, 16'd15);
    finish_cmd();
    issue("R8 chan16", 16'h8408, 16'd16);
    issue("R10 pwr clears err", 16'h8409, 16'd200);

    // R7 write while busy, same cycle as done
    @(negedge clk);
    bus_addr = 8'h10; bus_wdata = 16'h8401; bus_wr = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_done = 1'b0;
    exp_busy = 1'b0;
    chk("R7 coincident valid", {15'b0, cmd_valid}, 16'h0);
    chk("R7 coincident code", cmd_code, 16'h8409);
    rd(8'h10, d); chk("R7 coincident readback", d, cmd_read());

    // R9 bit 15 clear ignored
    issue("R9 no marker", 16'h0401, 16'd3);

    // Random traffic
    for (int i = 0; i < 200; i++) begin
      logic [15:0] c;
      logic [15:0] p;
      int sel;
      sel = $urandom % 6;
      p = 16'($urandom % 24);
      case (sel)
        0: c = 16'h8401;
        1, 2: c = 16'h8408;
        3: c = 16'h8409;
        4: c = 16'($urandom) & 16'h7FFF;
        default: c = 16'($urandom) | 16'h8000;
      endcase
      issue("R4 R8 R9 random", c, p);
      if (exp_busy) begin
        if ($urandom % 2 == 1) issue("R7 busy write", 16'h8401, 16'd1);
        repeat ($urandom % 5) @(negedge clk);
        rd(8'h10, d); chk("R6 still busy", d, cmd_read());
        finish_cmd();
        rd(8'h10, d); chk("R6 done random", d, cmd_read());
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule